// File: doc/BRIEF.md
# Packetized SPI master with pause

The block is a register-programmed SPI master. Software programs four timing values (SCK high and low half-periods, chip-select setup before the first clock and hold after the last one) and a framing word (chip-select idle gap, bytes per packet, packets per transfer). It fills a byte-wide transmit queue through a 32-bit data port and issues a start command. The engine then runs `(length+1) * (loops+1)` bytes in one chip-select window, shifting each transmit byte out and collecting each received byte into the receive queue, which software drains through a second 32-bit port.

With the pause option set, the end of the programmed bytes does not close the window. Chip select stays active, the engine parks and raises a pause event. Software reloads the transmit queue and issues resume, and clocking restarts without another setup period. Without pause, the engine holds chip select for the hold time, releases it, keeps it released for the idle gap and raises a finish event. Both events are latched in a status word. They drive one interrupt line through per-event enables, and a read of the status word clears them.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, irq is 0 and the status word reads 0.
- R2: Register word index `reg_idx`: 0 timing, 1 framing, 4 transmit write port, 5 receive read port, 6 command, 7 status. Timing fields are SCK-high at [7:0], SCK-low at [15:8], CS hold at [23:16] and CS setup at [31:24], each in core cycles minus one. Framing fields are idle gap minus one at [7:0], loops minus one at [15:8] and packet bytes minus one at [25:16].
- R3: For one transfer without pause, cs_n stays low for exactly `(setup+1) + bytes*8*(high+low+2) + (hold+1)` core cycles.
- R4: Command bit 9 sets the SCK idle level (CPOL). Command bit 8 (CPHA) selects whether the first SCK edge of each bit is the sampling edge (0) or the launch edge (1). In all four modes, a loopback of mosi to miso returns the transmitted bits.
- R5: Command bit 12 selects MSB-first transmit and bit 13 selects MSB-first receive, independently. If only transmit is MSB-first, each looped-back byte arrives bit-reversed.
- R6: One start moves `(length+1)*(loops+1)` bytes. Within each 32-bit word, byte 0 (bits 7:0) is sent or stored first.
- R7: With command bit 4 (pause) set, the end of the programmed bytes sets status bit 1 and keeps cs_n low. A resume (command bit 1) restarts clocking on the following cycle with no setup period and sends the newly loaded bytes.
- R8: With pause clear, the end of the programmed bytes sets status bit 0 at the same moment cs_n returns high.
- R9: irq is high exactly while a status bit is set together with its enable (bit 16 finish, bit 17 pause). A status read clears the status word, but an event that arrives in the same cycle as the read is kept.
- R10: Command bit 2 (soft reset) returns the engine to idle from any state on the next cycle: cs_n high, status cleared, both queues emptied.
- R11: After a transfer, cs_n stays high for exactly idle+1 cycles before the next one, even when start (command bit 0) arrives inside the gap; such a start is remembered and taken when the gap ends.
- R12: The transmit queue is emptied when the programmed bytes complete. The receive queue is emptied by start and by resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data, clears status) |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The status register can be read and loaded by the engine in the same cycle. A status read that clears a pending event can land on the edge where a finish or pause event is raised. The bench provokes this by reading the status word on every cycle while a paused transfer completes, so one of those reads coincides with the event. The run passes only if the pause bit is seen exactly once and the interrupt drops after that read. A cleared bit that beats the incoming event would never be seen, and the run would time out as a failure.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  localparam int TIME_W = 8;
  localparam int LEN_W  = 10;
  localparam int LOOP_W = 8;

  localparam logic [2:0] IDX_TIMING = 3'd0;
  localparam logic [2:0] IDX_FRAME  = 3'd1;
  localparam logic [2:0] IDX_TXD    = 3'd4;
  localparam logic [2:0] IDX_RXD    = 3'd5;
  localparam logic [2:0] IDX_CMD    = 3'd6;
  localparam logic [2:0] IDX_STAT   = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LEAD, ST_TRAIL, ST_HOLD, ST_GAP, ST_PAUSE
  } eng_state_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic tx_msb;
    logic rx_msb;
    logic pause_en;
  } spi_mode_t;
endpackage

// File: rtl/spi_pkt_fifo.sv
module spi_pkt_fifo #(
  parameter int DEPTH  = 32,
  parameter int PUSH_B = 4,
  parameter int POP_B  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic [8*PUSH_B-1:0]  push_data,
  input  logic                 pop,
  output logic [8*POP_B-1:0]   pop_data
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, wptr_n, rptr, rptr_n;

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    if (clr) begin
      wptr_n = '0;
      rptr_n = '0;
    end else begin
      if (push) wptr_n = wptr + AW'(PUSH_B);
      if (pop)  rptr_n = rptr + AW'(POP_B);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      wptr <= wptr_n;
      rptr <= rptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) begin
      for (int i = 0; i < PUSH_B; i++) begin
        mem[wptr + AW'(i)] <= push_data[8*i +: 8];
      end
    end
  end

  for (genvar g = 0; g < POP_B; g++) begin : g_pop
    assign pop_data[8*g +: 8] = mem[rptr + AW'(g)];
  end
endmodule

// File: rtl/spi_pkt_engine.sv
module spi_pkt_engine
  import spi_pkt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4*TIME_W-1:0]   timing,
  input  logic [LEN_W-1:0]      frame_len,
  input  logic [LOOP_W-1:0]     frame_loops,
  input  logic [TIME_W-1:0]     t_idle,
  input  spi_mode_t             mode,
  input  logic                  start,
  input  logic                  resume,
  input  logic                  srst,
  input  logic [7:0]            tx_byte,
  input  logic                  miso,
  output logic                  sck,
  output logic                  cs_n,
  output logic                  mosi,
  output logic                  tx_pop,
  output logic                  rx_push,
  output logic [7:0]            rx_byte,
  output logic                  chunk_end,
  output logic                  fin_evt,
  output logic                  pause_evt
);
  eng_state_e         st, st_n;
  logic [TIME_W-1:0]  cnt, cnt_n;
  logic [2:0]         bit_i, bit_n;
  logic [LEN_W-1:0]   byte_i, byte_n;
  logic [LOOP_W-1:0]  loop_i, loop_n;
  logic [7:0]         rx_sh, rx_n;
  logic               pend, pend_n;

  logic [TIME_W-1:0] t_hi, t_lo, t_hold, t_setup, lead_len, trail_len;
  logic              lead_lvl, last_byte;
  logic [2:0]        tx_idx, rx_idx;

  assign t_hi      = timing[0*TIME_W +: TIME_W];
  assign t_lo      = timing[1*TIME_W +: TIME_W];
  assign t_hold    = timing[2*TIME_W +: TIME_W];
  assign t_setup   = timing[3*TIME_W +: TIME_W];
  assign lead_lvl  = mode.cpol ^ mode.cpha;
  assign lead_len  = lead_lvl ? t_hi : t_lo;
  assign trail_len = lead_lvl ? t_lo : t_hi;
  assign last_byte = (byte_i == frame_len) && (loop_i == frame_loops);
  assign tx_idx    = mode.tx_msb ? 3'd7 - bit_i : bit_i;
  assign rx_idx    = mode.rx_msb ? 3'd7 - bit_i : bit_i;

  always_comb begin
    st_n = st; cnt_n = cnt + 1'b1; bit_n = bit_i; byte_n = byte_i;
    loop_n = loop_i; pend_n = pend; rx_n = rx_sh;
    tx_pop = 1'b0; rx_push = 1'b0; chunk_end = 1'b0;
    fin_evt = 1'b0; pause_evt = 1'b0;
    case (st)
      ST_IDLE: begin
        cnt_n = '0; bit_n = '0; byte_n = '0; loop_n = '0;
        if (start) st_n = ST_SETUP;
      end
      ST_SETUP: if (cnt == t_setup) begin st_n = ST_LEAD; cnt_n = '0; end
      ST_LEAD: if (cnt == lead_len) begin
        st_n = ST_TRAIL; cnt_n = '0; rx_n[rx_idx] = miso;
      end
      ST_TRAIL: if (cnt == trail_len) begin
        cnt_n = '0;
        if (bit_i != 3'd7) begin
          bit_n = bit_i + 3'd1; st_n = ST_LEAD;
        end else begin
          bit_n = '0; tx_pop = 1'b1; rx_push = 1'b1;
          if (last_byte) begin
            chunk_end = 1'b1; byte_n = '0; loop_n = '0;
            if (mode.pause_en) begin st_n = ST_PAUSE; pause_evt = 1'b1; end
            else st_n = ST_HOLD;
          end else begin
            st_n = ST_LEAD;
            if (byte_i == frame_len) begin byte_n = '0; loop_n = loop_i + 1'b1; end
            else byte_n = byte_i + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (start) pend_n = 1'b1;
        if (cnt == t_hold) begin st_n = ST_GAP; cnt_n = '0; fin_evt = 1'b1; end
      end
      ST_GAP: begin
        if (start) pend_n = 1'b1;
        if (cnt == t_idle) begin
          cnt_n = '0; pend_n = 1'b0;
          st_n = (pend || start) ? ST_SETUP : ST_IDLE;
        end
      end
      ST_PAUSE: begin
        cnt_n = '0;
        if (resume) st_n = ST_LEAD;
      end
      default: st_n = ST_IDLE;
    endcase
    if (srst) begin
      st_n = ST_IDLE; pend_n = 1'b0; cnt_n = '0;
      bit_n = '0; byte_n = '0; loop_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; bit_i <= '0; byte_i <= '0;
      loop_i <= '0; rx_sh <= '0; pend <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; bit_i <= bit_n; byte_i <= byte_n;
      loop_i <= loop_n; rx_sh <= rx_n; pend <= pend_n;
    end
  end

  assign cs_n    = (st == ST_IDLE) || (st == ST_GAP);
  assign sck     = (st == ST_LEAD) ? lead_lvl : (st == ST_TRAIL) ? ~lead_lvl : mode.cpol;
  assign mosi    = ((st == ST_LEAD) || (st == ST_TRAIL)) ? tx_byte[tx_idx] : 1'b0;
  assign rx_byte = rx_sh;

  AST_RESUME_NO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAUSE && resume && !srst) |=> (st == ST_LEAD)); // R7
  AST_GAP_KEEPS_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && cnt != t_idle && !srst) |=> cs_n); // R11
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == mode.cpol)); // R4
endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
  import spi_pkt_pkg::*;
#(
  parameter int FIFO_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic [4*TIME_W-1:0] timing_q;
  logic [TIME_W-1:0]   idle_q;
  logic [LOOP_W-1:0]   loops_q;
  logic [LEN_W-1:0]    len_q;
  spi_mode_t           mode_q;
  logic                fin_ie_q, pause_ie_q;
  logic [1:0]          stat_q, stat_n;

  logic we_timing, we_frame, we_cmd, push_tx, pop_rx, rd_stat;
  logic start, resume, srst;

  assign we_timing = reg_wr && (reg_idx == IDX_TIMING);
  assign we_frame  = reg_wr && (reg_idx == IDX_FRAME);
  assign we_cmd    = reg_wr && (reg_idx == IDX_CMD);
  assign push_tx   = reg_wr && (reg_idx == IDX_TXD);
  assign pop_rx    = reg_rd && (reg_idx == IDX_RXD);
  assign rd_stat   = reg_rd && (reg_idx == IDX_STAT);
  assign start     = we_cmd && reg_wdata[0];
  assign resume    = we_cmd && reg_wdata[1];
  assign srst      = we_cmd && reg_wdata[2];

  logic       tx_pop, rx_push, chunk_end, fin_evt, pause_evt;
  logic [7:0] tx_byte, rx_byte;
  logic [31:0] rx_word;

  always_comb begin
    stat_n = (stat_q & ~{2{rd_stat}}) | {pause_evt, fin_evt};
    if (srst) stat_n = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q <= '0; idle_q <= '0; loops_q <= '0; len_q <= '0;
      mode_q <= '0; fin_ie_q <= 1'b0; pause_ie_q <= 1'b0; stat_q <= 2'b00;
    end else begin
      if (we_timing) timing_q <= reg_wdata;
      if (we_frame) begin
        idle_q  <= reg_wdata[7:0];
        loops_q <= reg_wdata[15:8];
        len_q   <= reg_wdata[25:16];
      end
      if (we_cmd) begin
        mode_q.pause_en <= reg_wdata[4];
        mode_q.cpha     <= reg_wdata[8];
        mode_q.cpol     <= reg_wdata[9];
        mode_q.tx_msb   <= reg_wdata[12];
        mode_q.rx_msb   <= reg_wdata[13];
        fin_ie_q        <= reg_wdata[16];
        pause_ie_q      <= reg_wdata[17];
      end
      stat_q <= stat_n;
    end
  end

  spi_pkt_fifo #(.DEPTH(FIFO_BYTES), .PUSH_B(4), .POP_B(1)) i_txq (
    .clk(clk), .rst_n(rst_ni), .clr(srst || chunk_end),
    .push(push_tx), .push_data(reg_wdata), .pop(tx_pop), .pop_data(tx_byte)
  );

  spi_pkt_fifo #(.DEPTH(FIFO_BYTES), .PUSH_B(1), .POP_B(4)) i_rxq (
    .clk(clk), .rst_n(rst_ni), .clr(srst || start || resume),
    .push(rx_push), .push_data(rx_byte), .pop(pop_rx), .pop_data(rx_word)
  );

  spi_pkt_engine i_eng (
    .clk(clk), .rst_n(rst_ni), .timing(timing_q), .frame_len(len_q),
    .frame_loops(loops_q), .t_idle(idle_q), .mode(mode_q),
    .start(start), .resume(resume), .srst(srst), .tx_byte(tx_byte), .miso(miso),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_byte(rx_byte), .chunk_end(chunk_end), .fin_evt(fin_evt), .pause_evt(pause_evt)
  );

  always_comb begin
    case (reg_idx)
      IDX_TIMING: reg_rdata = timing_q;
      IDX_FRAME:  reg_rdata = {6'b0, len_q, loops_q, idle_q};
      IDX_RXD:    reg_rdata = rx_word;
      IDX_CMD:    reg_rdata = {14'b0, pause_ie_q, fin_ie_q, 2'b0, mode_q.rx_msb,
                               mode_q.tx_msb, 2'b0, mode_q.cpol, mode_q.cpha,
                               3'b0, mode_q.pause_en, 4'b0};
      IDX_STAT:   reg_rdata = {30'b0, stat_q};
      default:    reg_rdata = 32'b0;
    endcase
  end

  assign irq = (stat_q[0] && fin_ie_q) || (stat_q[1] && pause_ie_q);

  AST_PAUSE_CS_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (pause_evt && !srst) |=> !cs_n); // R7
  AST_FINISH_CS_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    (fin_evt && !srst) |=> cs_n); // R8
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (fin_evt && !srst) |=> stat_q[0]); // R9
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    srst |=> (cs_n && !irq)); // R10
endmodule

// File: tb/test_spi_pkt_master.sv
module test_spi_pkt_master;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, reg_rd, miso;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sck, cs_n, mosi, irq;

  spi_pkt_master i_spi_pkt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .irq(irq)
  );

  assign miso = mosi;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cs_low = 0, hi_run = 0, last_hi = 0, rises = 0;
  logic cs_prev = 1'b1;

  always @(negedge clk) begin
    if (!cs_n) cs_low = cs_low + 1;
    if (cs_n) hi_run = hi_run + 1;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
    if (cs_n && !cs_prev) rises = rises + 1;
    cs_prev = cs_n;
  end

  typedef struct packed {
    logic [31:0] timing;
    logic [31:0] frame;
    logic [31:0] mode;
    logic [31:0] tx;
    logic [31:0] rx;
  } vec_t;

  // timing {setup,hold,low,high}; frame {len,loops,idle}; mode = command bits
  localparam vec_t VECS [4] = '{
    '{32'h03020101, 32'h00030001, 32'h00013000, 32'hA5C30F81, 32'hA5C30F81},
    '{32'h01010200, 32'h00030000, 32'h00011100, 32'h12345678, 32'h482C6A1E},
    '{32'h00000000, 32'h00000000, 32'h00012300, 32'h000000F0, 32'h0000000F},
    '{32'h02010302, 32'h00010100, 32'h00010200, 32'hDEADBEEF, 32'hDEADBEEF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    reg_idx = i; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    int n = 0;
    @(negedge clk);
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
    seen = irq;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d, mask;
    bit seen;
    int nb, exp_cs, hits;
    reg_wr = 0; reg_rd = 0; reg_idx = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n after reset", {31'b0, cs_n}, 32'h1);
    chk(sck == 1'b0, "R1", "sck after reset", {31'b0, sck}, 32'h0);
    chk(irq == 1'b0, "R1", "irq after reset", {31'b0, irq}, 32'h0);
    rd(3'd7, d);
    chk(d == 32'h0, "R1", "status after reset", d, 32'h0);

    // Vector walk: R2 R3 R4 R5 R6 R8 R12
    for (int v = 0; v < 4; v++) begin
      wr(3'd0, VECS[v].timing);
      wr(3'd1, VECS[v].frame);
      wr(3'd6, VECS[v].mode);
      wr(3'd4, VECS[v].tx);
      nb = (int'(VECS[v].frame[25:16]) + 1) * (int'(VECS[v].frame[15:8]) + 1);
      exp_cs = int'(VECS[v].timing[31:24]) + 1 + int'(VECS[v].timing[23:16]) + 1 +
               nb * 8 * (int'(VECS[v].timing[7:0]) + int'(VECS[v].timing[15:8]) + 2);
      cs_low = 0;
      wr(3'd6, VECS[v].mode | 32'h1);
      wait_irq(seen);
      chk(seen, "R8", "finish interrupt raised", {31'b0, seen}, 32'h1);
      chk(cs_n == 1'b1, "R8", "cs_n released at finish", {31'b0, cs_n}, 32'h1);
      chk(cs_low == exp_cs, "R3", "cs low cycles", cs_low, exp_cs);
      rd(3'd7, d);
      chk(d == 32'h1, "R8", "status finish bit", d, 32'h1);
      mask = (nb >= 4) ? 32'hFFFFFFFF : ((32'h1 << (8 * nb)) - 1);
      rd(3'd5, d);
      chk((d & mask) == VECS[v].rx, "R4 R5 R6 R12", "looped-back word", d & mask, VECS[v].rx);
      @(negedge clk);
      chk(irq == 1'b0, "R9", "irq cleared by status read", {31'b0, irq}, 32'h0);
    end

    // R7 pause / resume, R9 read coinciding with event
    wr(3'd0, 32'h01010000);
    wr(3'd1, 32'h00010002);
    wr(3'd4, 32'h0000BEEF);
    rises = 0;
    wr(3'd6, 32'h00033111);
    hits = 0; d = 0;
    for (int n = 0; n < 3000 && hits == 0; n++) begin
      rd(3'd7, d);
      if (d != 0) hits++;
    end
    chk(d == 32'h2, "R9", "pause seen by polling read", d, 32'h2);
    @(negedge clk);
    chk(irq == 1'b0, "R9", "irq after clearing read", {31'b0, irq}, 32'h0);
    chk(cs_n == 1'b0, "R7", "cs held while paused", {31'b0, cs_n}, 32'h0);
    rd(3'd5, d);
    chk(d[15:0] == 16'hBEEF, "R7", "first chunk data", {16'b0, d[15:0]}, 32'hBEEF);
    wr(3'd4, 32'h00001234);
    wr(3'd6, 32'h00033102);
    @(negedge clk);
    chk(sck == 1'b1, "R7", "clocking resumes without setup", {31'b0, sck}, 32'h1);
    wait_irq(seen);
    rd(3'd7, d);
    chk(d == 32'h1, "R8", "finish after resume", d, 32'h1);
    chk(rises == 1, "R7", "cs released only once", rises, 1);
    rd(3'd5, d);
    chk(d[15:0] == 16'h1234, "R7 R12", "second chunk data", {16'b0, d[15:0]}, 32'h1234);

    // R10 soft reset while paused
    wr(3'd4, 32'h00005555);
    wr(3'd6, 32'h00033111);
    wait_irq(seen);
    chk(cs_n == 1'b0, "R7", "paused before soft reset", {31'b0, cs_n}, 32'h0);
    wr(3'd6, 32'h00033114);
    @(negedge clk);
    chk(cs_n == 1'b1 && irq == 1'b0, "R10", "cs_n and irq after soft reset",
        {30'b0, cs_n, irq}, 32'h2);
    rd(3'd7, d);
    chk(d == 32'h0, "R10", "status after soft reset", d, 32'h0);

    // R9 enable off: status set, irq stays low
    wr(3'd0, 32'h00000000);
    wr(3'd1, 32'h00000000);
    wr(3'd4, 32'h0000003C);
    wr(3'd6, 32'h00003001);
    repeat (40) @(negedge clk);
    chk(irq == 1'b0, "R9", "irq masked", {31'b0, irq}, 32'h0);
    rd(3'd7, d);
    chk(d == 32'h1, "R9", "masked finish still latched", d, 32'h1);
    rd(3'd5, d);
    chk(d[7:0] == 8'h3C, "R10", "transfer works after soft reset", {24'b0, d[7:0]}, 32'h3C);

    // R11 start inside idle gap
    wr(3'd0, 32'h03020101);
    wr(3'd1, 32'h00030005);
    wr(3'd4, 32'h11223344);
    wr(3'd6, 32'h00013001);
    wait_irq(seen);
    wr(3'd6, 32'h00013001);
    rd(3'd7, d);
    wait_irq(seen);
    chk(seen, "R11", "pending start ran", {31'b0, seen}, 32'h1);
    chk(last_hi == 6, "R11", "cs high cycles in gap", last_hi, 6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule